// File: doc/BRIEF.md
# Reflecting Rotor Substitution Datapath

The block carries one n-bit symbol through a keyed substitution network of the kind used in rotor machines, with the network folded back on itself. A symbol first goes through a keyed initial permutation. It then passes forward through a chain of rotor stages and meets a reflector. After the reflector it runs back through the same rotors, each using its inverse table, in the opposite order. It leaves through the inverse of the initial permutation. Each rotor stage shifts the symbol by the rotor's current position, looks it up in that rotor's table, and removes the shift again. Even-numbered stages turn one way and odd-numbered stages turn the other, so the two kinds apply the shift and the unshift in opposite order.

The caller supplies a symbol, a valid strobe and the current position of every rotor, and gets a symbol and a valid strobe back a fixed number of cycles later. One symbol can enter on every cycle. Each symbol carries its own rotor positions through the pipeline, so the positions may change on every cycle. All tables sit in registers and are filled through a simple write port. A forward write fills the matching inverse entry in the same cycle. Because the chain is mirrored around a reflector that has no fixed points, running the block's output through it again with the same positions gives back the original symbol. The logic that steps the rotor positions is not part of this block.

Top module: `rotor_reflect_path`

## Requirements
- R1: A clock edge with rst_n low clears out_vld, which stays 0 until a valid symbol has passed through the pipeline. It also sets every table (rotors, initial permutation, reflector) to the identity, so that after reset out_sym equals the in_sym that was presented with it, whatever the positions.
- R2: A symbol sampled with in_vld high at a rising edge appears with out_vld high right after the 2*NUM_ROT+3-th rising edge, counting the sampling edge as the first (19 edges by default). Symbols may enter on consecutive cycles. A cycle with in_vld low gives a cycle with out_vld low at the same distance.
- R3: The output is P⁻¹(B₀(…B₇(F(A₇(…A₀(P(x)))))…)), where P is the initial permutation, A_k is forward rotor stage k with table S_k, F is the reflector, and B_k is rotor stage k with the inverse table S_k⁻¹.
- R4: Rotor position c for stage k is in_offs[k*SYM_W +: SYM_W]. Even k turns one way and computes T(v + c) − c. Odd k turns the other way and computes T(v − c) + c, where T is S_k going forward and S_k⁻¹ coming back.
- R5: All position arithmetic is modulo 2^SYM_W and wraps within SYM_W bits. For example, a symbol of 2^SYM_W−1 with a position of 1 indexes table entry 0.
- R6: A write with cfg_we high at a rising edge loads the table named by cfg_sel: values 0 to NUM_ROT−1 select rotor k, NUM_ROT selects the initial permutation, and NUM_ROT+1 selects the reflector. For a rotor or the initial permutation it sets forward[cfg_addr]=cfg_data and inverse[cfg_data]=cfg_addr. For the reflector it sets both F[cfg_addr]=cfg_data and F[cfg_data]=cfg_addr, and cfg_addr must differ from cfg_data.
- R7: The positions used on the return pass are those that were sampled together with the symbol. Positions presented on later cycles do not affect a symbol already in flight.
- R8: When every table is a permutation and the reflector is a fixed-point-free involution, feeding an output symbol back in with the same positions returns the original input symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input symbol valid |
| in_sym | input | SYM_W | Input symbol |
| in_offs | input | NUM_ROT*SYM_W | Rotor positions, slot k at bits k*SYM_W upward |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | $clog2(NUM_ROT+2) | Table select: rotor k, then initial permutation, then reflector |
| cfg_addr | input | SYM_W | Table entry index |
| cfg_data | input | SYM_W | Table entry value |
| out_vld | output | 1 | Output symbol valid |
| out_sym | output | SYM_W | Output symbol |

## Verification
The per-stage assertions assume that every table loaded is a permutation written one entry per address, so each inverse table really inverts its forward table. They also assume no write lands while the stage under check holds the result. The reflector assertions assume every written pair joins two different symbols. The stimulus builds every table by shuffling the identity, loads each address once, and pairs the reflector from a shuffled list. It loads only while in_vld is low and the pipeline has drained, and it never selects a table index above the reflector.

// File: rtl/rotor_pkg.sv
// Package: shared types for the reflecting rotor datapath.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rotor_pkg;

    // Kind of substitution a pipeline stage performs.
    typedef enum logic [1:0] {
        MAP_PLAIN = 2'd0,   // table lookup only
        MAP_CW    = 2'd1,   // T(v + c) - c
        MAP_CCW   = 2'd2    // T(v - c) + c
    } map_kind_e;

    // Number of registered stages for a given rotor count.
    function automatic int stage_count(input int nrot);
        return 2 * nrot + 3;
    endfunction

    // Rotor sense for a forward slot: even slots turn one way, odd the other.
    function automatic map_kind_e slot_kind(input int slot);
        return (slot % 2 == 0) ? MAP_CW : MAP_CCW;
    endfunction

endpackage

// File: rtl/perm_table.sv
// Module: perm_table
// Holds one keyed substitution table of 2^W entries in registers, together
// with its inverse. A write of (addr, data) stores forward[addr]=data and
// inverse[data]=addr in one cycle. With REFLECT set, the table is its own
// inverse: a write stores both addr->data and data->addr.
// Assumes: the caller loads a permutation with each address written once;
// for a reflector, addr differs from data on every write.
module perm_table #(
    parameter int W       = 5,
    parameter bit REFLECT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] data,
    output logic [W-1:0] fwd [1<<W],
    output logic [W-1:0] inv [1<<W]
);
    localparam int N = 1 << W;

    generate
        if (REFLECT) begin : g_refl
            // Reflector storage: paired symmetric write, reset to identity.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < N; i++) fwd[i] <= W'(i);
                end else if (we) begin
                    fwd[addr] <= data;
                    fwd[data] <= addr;
                end
            end

            // Inverse view of an involution is the table itself.
            always_comb begin
                for (int i = 0; i < N; i++) inv[i] = fwd[i];
            end

            // Each written pair must join two distinct symbols.
            AST_REFL_NO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
                we |-> (addr != data)) else $error("reflector fixed point");  // R6
        end else begin : g_perm
            // Forward and inverse storage, written together, reset to identity.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < N; i++) begin
                        fwd[i] <= W'(i);
                        inv[i] <= W'(i);
                    end
                end else if (we) begin
                    fwd[addr] <= data;
                    inv[data] <= addr;
                end
            end
        end
    endgenerate

    // A write is visible in both directions on the next cycle.
    AST_PAIR_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((fwd[$past(addr)] == $past(data)) && (inv[$past(data)] == $past(addr))))
        else $error("table pair not written");  // R6

endmodule

// File: rtl/sub_stage.sv
// Module: sub_stage
// One registered stage of the datapath. It takes the symbol, applies the
// rotor position of slot SLOT (per MODE), looks up table lk, and registers
// the result along with the valid bit and the full position word.
// Assumes: chk is the inverse of lk, so the assertion can undo each result;
// no table write lands in the cycle being checked (tbl_wr is the write strobe).
module sub_stage
    import rotor_pkg::*;
#(
    parameter int        W    = 5,
    parameter int        NROT = 8,
    parameter map_kind_e MODE = MAP_PLAIN,
    parameter int        SLOT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [W-1:0]      in_sym,
    input  logic [NROT*W-1:0] in_offs,
    input  logic [W-1:0]      lk  [1<<W],
    input  logic [W-1:0]      chk [1<<W],
    input  logic              tbl_wr,
    output logic              out_vld,
    output logic [W-1:0]      out_sym,
    output logic [NROT*W-1:0] out_offs
);
    logic [W-1:0] pos;
    logic [W-1:0] idx;
    logic [W-1:0] looked;
    logic [W-1:0] res;

    // Shift into the rotor frame, look up, shift back out.
    always_comb begin
        pos    = in_offs[SLOT*W +: W];
        unique case (MODE)
            MAP_CW:  idx = in_sym + pos;
            MAP_CCW: idx = in_sym - pos;
            default: idx = in_sym;
        endcase
        looked = lk[idx];
        unique case (MODE)
            MAP_CW:  res = looked - pos;
            MAP_CCW: res = looked + pos;
            default: res = looked;
        endcase
    end

    // Stage register: valid, symbol and the positions travel together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_sym  <= '0;
            out_offs <= '0;
        end else begin
            out_vld  <= in_vld;
            out_sym  <= res;
            out_offs <= in_offs;
        end
    end

    // Undo the registered result with the inverse table (for checking only).
    logic [W-1:0] o_pos;
    logic [W-1:0] u_idx;
    logic [W-1:0] undo;
    always_comb begin
        o_pos = out_offs[SLOT*W +: W];
        unique case (MODE)
            MAP_CW:  u_idx = out_sym + o_pos;
            MAP_CCW: u_idx = out_sym - o_pos;
            default: u_idx = out_sym;
        endcase
        unique case (MODE)
            MAP_CW:  undo = chk[u_idx] - o_pos;
            MAP_CCW: undo = chk[u_idx] + o_pos;
            default: undo = chk[u_idx];
        endcase
    end

    // The stage's result must invert back to the symbol it took in.
    AST_STAGE_UNDOES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !$past(tbl_wr)) |-> (undo == $past(in_sym)))
        else $error("stage result not invertible");  // R4

endmodule

// File: rtl/rotor_reflect_path.sv
// Module: rotor_reflect_path (top)
// Pipelined reflecting rotor network: initial permutation, NUM_ROT forward
// rotor stages, reflector, NUM_ROT return stages with inverse tables in
// reverse order, inverse initial permutation. One register per stage, so
// latency is 2*NUM_ROT+3 cycles; one symbol may enter every cycle.
// Assumes: tables are loaded only while no valid symbol is in flight.
module rotor_reflect_path
    import rotor_pkg::*;
#(
    parameter int SYM_W   = 5,
    parameter int NUM_ROT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    input  logic [SYM_W-1:0]             in_sym,
    input  logic [NUM_ROT*SYM_W-1:0]     in_offs,
    input  logic                         cfg_we,
    input  logic [$clog2(NUM_ROT+2)-1:0] cfg_sel,
    input  logic [SYM_W-1:0]             cfg_addr,
    input  logic [SYM_W-1:0]             cfg_data,
    output logic                         out_vld,
    output logic [SYM_W-1:0]             out_sym
);
    localparam int N       = 1 << SYM_W;
    localparam int LAT     = stage_count(NUM_ROT);
    localparam int OFF_W   = NUM_ROT * SYM_W;
    localparam int SEL_W   = $clog2(NUM_ROT + 2);
    localparam int IP_SEL  = NUM_ROT;
    localparam int REF_SEL = NUM_ROT + 1;

    // Table storage.
    logic [SYM_W-1:0] rot_f [NUM_ROT][N];
    logic [SYM_W-1:0] rot_i [NUM_ROT][N];
    logic [SYM_W-1:0] ip_f  [N];
    logic [SYM_W-1:0] ip_i  [N];
    logic [SYM_W-1:0] ref_t [N];
    logic [SYM_W-1:0] ref_v [N];

    // Pipeline links: index 0 is the block input, index LAT the output.
    logic             p_vld [LAT+1];
    logic [SYM_W-1:0] p_sym [LAT+1];
    logic [OFF_W-1:0] p_off [LAT+1];

    // Input feeds link 0.
    always_comb begin
        p_vld[0] = in_vld;
        p_sym[0] = in_sym;
        p_off[0] = in_offs;
    end

    // Rotor tables, one per slot, each selected by its own index.
    generate
        for (genvar k = 0; k < NUM_ROT; k++) begin : g_rot_tbl
            perm_table #(.W(SYM_W), .REFLECT(1'b0)) u_tbl (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (cfg_we && (cfg_sel == SEL_W'(k))),
                .addr  (cfg_addr),
                .data  (cfg_data),
                .fwd   (rot_f[k]),
                .inv   (rot_i[k])
            );
        end
    endgenerate

    // Initial permutation table.
    perm_table #(.W(SYM_W), .REFLECT(1'b0)) u_ip_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we && (cfg_sel == SEL_W'(IP_SEL))),
        .addr  (cfg_addr),
        .data  (cfg_data),
        .fwd   (ip_f),
        .inv   (ip_i)
    );

    // Reflector table.
    perm_table #(.W(SYM_W), .REFLECT(1'b1)) u_ref_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we && (cfg_sel == SEL_W'(REF_SEL))),
        .addr  (cfg_addr),
        .data  (cfg_data),
        .fwd   (ref_t),
        .inv   (ref_v)
    );

    // Stage chain: each position j picks its table and rotor sense.
    generate
        for (genvar j = 0; j < LAT; j++) begin : g_stage
            if (j == 0) begin : g_ip
                sub_stage #(.W(SYM_W), .NROT(NUM_ROT), .MODE(MAP_PLAIN), .SLOT(0)) u_st (
                    .clk(clk), .rst_n(rst_n),
                    .in_vld(p_vld[j]), .in_sym(p_sym[j]), .in_offs(p_off[j]),
                    .lk(ip_f), .chk(ip_i), .tbl_wr(cfg_we),
                    .out_vld(p_vld[j+1]), .out_sym(p_sym[j+1]), .out_offs(p_off[j+1])
                );
            end else if (j <= NUM_ROT) begin : g_fwd
                sub_stage #(.W(SYM_W), .NROT(NUM_ROT), .MODE(slot_kind(j-1)), .SLOT(j-1)) u_st (
                    .clk(clk), .rst_n(rst_n),
                    .in_vld(p_vld[j]), .in_sym(p_sym[j]), .in_offs(p_off[j]),
                    .lk(rot_f[j-1]), .chk(rot_i[j-1]), .tbl_wr(cfg_we),
                    .out_vld(p_vld[j+1]), .out_sym(p_sym[j+1]), .out_offs(p_off[j+1])
                );
            end else if (j == NUM_ROT + 1) begin : g_ref
                sub_stage #(.W(SYM_W), .NROT(NUM_ROT), .MODE(MAP_PLAIN), .SLOT(0)) u_st (
                    .clk(clk), .rst_n(rst_n),
                    .in_vld(p_vld[j]), .in_sym(p_sym[j]), .in_offs(p_off[j]),
                    .lk(ref_t), .chk(ref_v), .tbl_wr(cfg_we),
                    .out_vld(p_vld[j+1]), .out_sym(p_sym[j+1]), .out_offs(p_off[j+1])
                );
            end else if (j <= 2 * NUM_ROT + 1) begin : g_back
                localparam int K = 2 * NUM_ROT + 1 - j;
                sub_stage #(.W(SYM_W), .NROT(NUM_ROT), .MODE(slot_kind(K)), .SLOT(K)) u_st (
                    .clk(clk), .rst_n(rst_n),
                    .in_vld(p_vld[j]), .in_sym(p_sym[j]), .in_offs(p_off[j]),
                    .lk(rot_i[K]), .chk(rot_f[K]), .tbl_wr(cfg_we),
                    .out_vld(p_vld[j+1]), .out_sym(p_sym[j+1]), .out_offs(p_off[j+1])
                );
            end else begin : g_ipinv
                sub_stage #(.W(SYM_W), .NROT(NUM_ROT), .MODE(MAP_PLAIN), .SLOT(0)) u_st (
                    .clk(clk), .rst_n(rst_n),
                    .in_vld(p_vld[j]), .in_sym(p_sym[j]), .in_offs(p_off[j]),
                    .lk(ip_i), .chk(ip_f), .tbl_wr(cfg_we),
                    .out_vld(p_vld[j+1]), .out_sym(p_sym[j+1]), .out_offs(p_off[j+1])
                );
            end
        end
    endgenerate

    // Outputs come from the last link.
    always_comb begin
        out_vld = p_vld[LAT];
        out_sym = p_sym[LAT];
    end

    // Writes may only name an existing table.
    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (int'(cfg_sel) <= REF_SEL)) else $error("bad table select");  // R6

    // Positions leave the chain exactly as they entered with the symbol.
    AST_POS_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        p_vld[NUM_ROT+2] |-> (p_off[NUM_ROT+2] == $past(p_off[NUM_ROT+1])))
        else $error("positions changed in flight");  // R7

    logic unused_tail;
    assign unused_tail = ^p_off[LAT];

endmodule

// File: tb/rotor_reflect_path_test.sv
`timescale 1ns/1ps
module rotor_reflect_path_test;
    localparam int W   = 5;
    localparam int NR  = 8;
    localparam int N   = 1 << W;
    localparam int LAT = 2 * NR + 3;
    localparam int SW  = $clog2(NR + 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_vld = 1'b0;
    logic [W-1:0]    in_sym = '0;
    logic [NR*W-1:0] in_offs = '0;
    logic            cfg_we = 1'b0;
    logic [SW-1:0]   cfg_sel = '0;
    logic [W-1:0]    cfg_addr = '0;
    logic [W-1:0]    cfg_data = '0;
    logic            out_vld;
    logic [W-1:0]    out_sym;

    rotor_reflect_path #(.SYM_W(W), .NUM_ROT(NR)) uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sym(in_sym), .in_offs(in_offs),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_vld(out_vld), .out_sym(out_sym)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R1";
    bit live = 1'b0;
    int unsigned seed = 32'h1234_5678;

    int ip_f [N];
    int ip_i [N];
    int rf   [N];
    int sf   [NR][N];
    int si   [NR][N];

    bit ev_q [$];
    int es_q [$];
    int obs_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'h7fff);
    endfunction

    function automatic void ident();
        for (int a = 0; a < N; a++) begin
            ip_f[a] = a; ip_i[a] = a; rf[a] = a;
            for (int k = 0; k < NR; k++) begin sf[k][a] = a; si[k][a] = a; end
        end
    endfunction

    // Reference: forward pass, reflector, return pass, all with integers.
    function automatic int model(input int x, input logic [NR*W-1:0] o);
        int v, c;
        v = ip_f[x];
        for (int k = 0; k < NR; k++) begin
            c = int'(o[k*W +: W]);
            if (k % 2 == 0) v = (sf[k][(v + c) % N] - c + N) % N;
            else            v = (sf[k][(v - c + N) % N] + c) % N;
        end
        v = rf[v];
        for (int k = NR - 1; k >= 0; k--) begin
            c = int'(o[k*W +: W]);
            if (k % 2 == 0) v = (si[k][(v + c) % N] - c + N) % N;
            else            v = (si[k][(v - c + N) % N] + c) % N;
        end
        return ip_i[v];
    endfunction

    // Record expectation for every sampled cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            ev_q.delete(); es_q.delete();
        end else begin
            ev_q.push_back(in_vld);
            es_q.push_back(model(int'(in_sym), in_offs));
        end
    end

    // Compare on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            if (ev_q.size() >= LAT) begin
                bit ev; int es;
                ev = ev_q.pop_front(); es = es_q.pop_front();
                check(out_vld == ev, "R2", int'(out_vld), int'(ev));
                if (ev) begin
                    check(int'(out_sym) == es, phase, int'(out_sym), es);
                    obs_q.push_back(int'(out_sym));
                end
            end else begin
                check(out_vld == 1'b0, "R1", int'(out_vld), 0);
            end
        end
    end

    task automatic send(input int s, input logic [NR*W-1:0] o);
        @(negedge clk);
        in_vld = 1'b1; in_sym = W'(s); in_offs = o;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_vld = 1'b0; in_offs = '0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NR*W-1:0] rnd_offs();
        logic [NR*W-1:0] o;
        for (int k = 0; k < NR; k++) o[k*W +: W] = W'(rnd());
        return o;
    endfunction

    task automatic wr(input int sel, input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_addr = W'(a); cfg_data = W'(d);
    endtask

    task automatic shuffle(output int p [N]);
        for (int a = 0; a < N; a++) p[a] = a;
        for (int a = N - 1; a > 0; a--) begin
            int j, t;
            j = rnd() % (a + 1);
            t = p[a]; p[a] = p[j]; p[j] = t;
        end
    endtask

    // R6: load every table through the write port.
    task automatic load_all();
        int p [N];
        for (int k = 0; k <= NR; k++) begin
            shuffle(p);
            for (int a = 0; a < N; a++) begin
                wr(k, a, p[a]);
                if (k == NR) begin ip_f[a] = p[a]; ip_i[p[a]] = a; end
                else begin sf[k][a] = p[a]; si[k][p[a]] = a; end
            end
        end
        shuffle(p);
        for (int i = 0; i < N / 2; i++) begin
            wr(NR + 1, p[2*i], p[2*i+1]);
            rf[p[2*i]] = p[2*i+1]; rf[p[2*i+1]] = p[2*i];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [NR*W-1:0] o;
        int orig [$];
        int first [$];
        ident();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        check(out_vld == 1'b0, "R1", int'(out_vld), 0);

        // R1: identity tables after reset give out == in.
        phase = "R1";
        for (int i = 0; i < 12; i++) send(i * 3, rnd_offs());
        idle(LAT + 2);

        // R6 / R3: loaded tables, back-to-back stream.
        load_all();
        phase = "R6";
        for (int i = 0; i < N; i++) send(i, '0);
        idle(LAT + 2);
        phase = "R3";
        for (int i = 0; i < 40; i++) send(rnd() % N, rnd_offs());
        idle(LAT + 2);

        // R2: gaps in the valid strobe.
        phase = "R2";
        for (int i = 0; i < 20; i++) begin
            send(rnd() % N, rnd_offs());
            if (i % 3 == 0) idle(i % 4);
        end
        idle(LAT + 2);

        // R4: one position non-zero at a time, both senses.
        phase = "R4";
        for (int k = 0; k < NR; k++) begin
            for (int s = 0; s < 4; s++) begin
                o = '0; o[k*W +: W] = W'(1 + s * 7);
                send(rnd() % N, o);
            end
        end
        idle(LAT + 2);

        // R5: wrap at the range limits.
        phase = "R5";
        for (int i = 0; i < 8; i++) begin
            o = '0;
            for (int k = 0; k < NR; k++) o[k*W +: W] = ((k + i) % 2 == 0) ? W'(N - 1) : W'(1);
            send((i % 2 == 0) ? N - 1 : 0, o);
        end
        idle(LAT + 2);

        // R7: positions change every cycle while symbols are in flight.
        phase = "R7";
        for (int i = 0; i < 30; i++) send(i % N, rnd_offs());
        idle(LAT + 2);

        // R8: output fed back with the same positions returns the input.
        phase = "R8";
        o = rnd_offs();
        obs_q.delete();
        for (int i = 0; i < 16; i++) begin orig.push_back(rnd() % N); send(orig[i], o); end
        idle(LAT + 2);
        first = obs_q;
        obs_q.delete();
        for (int i = 0; i < first.size(); i++) send(first[i], o);
        idle(LAT + 2);
        check(obs_q.size() == 16, "R8", obs_q.size(), 16);
        for (int i = 0; i < 16 && i < obs_q.size(); i++)
            check(obs_q[i] == orig[i], "R8", obs_q[i], orig[i]);

        // R1: reset with symbols in flight clears valid and tables.
        phase = "R1";
        for (int i = 0; i < 6; i++) send(i, rnd_offs());
        @(negedge clk);
        in_vld = 1'b0; rst_n = 1'b0;
        ident();
        @(negedge clk);
        rst_n = 1'b1;
        check(out_vld == 1'b0, "R1", int'(out_vld), 0);
        obs_q.delete();
        for (int i = 0; i < 6; i++) send(N - 1 - i, rnd_offs());
        idle(LAT + 2);
        for (int i = 0; i < 6 && i < obs_q.size(); i++)
            check(obs_q[i] == N - 1 - i, "R1", obs_q[i], N - 1 - i);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule